// File: doc/BRIEF.md
# Power-Good Window Monitor

This block decides when a regulator's power-good output may be released. It compares a digitised feedback code against a digitised reference code through two hysteretic windows: one for undervoltage, one for overvoltage. It also watches a group of system status flags. Its main output is a command for an open-drain pull-down. When that command is low, the power-good line is held low. When it is high, the line is released.

Each threshold is a ratio of the reference, given in parts per thousand. A comparison is an integer multiply-and-compare: code×1000 against reference×threshold. While soft-start is still running, the undervoltage window watches the soft-start ramp code instead of the feedback code. During that time the output is the AND of the soft-start-done flag and the undervoltage result, so it stays low.

Any fault flag, or loss of regulation, pulls the output low at once. Release is allowed only after a quiet time. An overvoltage must persist before it affects power-good. The raw, registered overvoltage state is also sent out undelayed, for a neighbouring fault controller.

Top module: `pg_window_mon`

## Requirements
- R1: While `rst_n` is low, `pg_pd_n` is 0 (pull down) and `ov_flag` is 0.
- R2: The undervoltage window reports "in regulation" once the monitored code ×1000 exceeds `ref_code`×910. It reports "low" once the code ×1000 drops below `ref_code`×870. Between those two points it keeps its state. A "low" result pulls `pg_pd_n` to 0 two clock edges after the input change.
- R3: `ov_flag` becomes 1 on the first clock edge where `fb_code`×1000 > `ref_code`×1165. It returns to 0 on the first edge where `fb_code`×1000 < `ref_code`×1130. Between those points it keeps its state, and it is not filtered.
- R4: An overvoltage pulls `pg_pd_n` to 0 only after `ov_flag` has been 1 on OV_HOLD consecutive edges, where OV_HOLD = CLK_MHZ×OV_DGL_NS/1000. `pg_pd_n` then falls on the following edge. A shorter overvoltage leaves `pg_pd_n` unchanged.
- R5: If any of `ilim_trip`, `uvlo_act`, `tsd_act`, `en_wait` or `off_req` is 1, `pg_pd_n` is 0 in the same cycle, without waiting for a clock edge.
- R6: While `ss_done` is 0, `pg_pd_n` is 0 and the undervoltage window watches `ss_code`. Once `ss_done` is 1, it watches `fb_code`.
- R7: `pg_pd_n` rises to 1 only after the good condition has held on PG_HOLD consecutive edges, where PG_HOLD = CLK_MHZ×FLAG_DGL_NS/1000. The good condition is: soft-start done, undervoltage window in regulation, filtered overvoltage clear, and no force flag. Any interruption restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_code | input | CODE_W | Feedback voltage code |
| ss_code | input | CODE_W | Soft-start ramp code |
| ref_code | input | CODE_W | Reference voltage code |
| ilim_trip | input | 1 | Heavy overcurrent in progress |
| uvlo_act | input | 1 | Supply undervoltage lockout active |
| tsd_act | input | 1 | Thermal shutdown active |
| en_wait | input | 1 | Enable delay still running |
| off_req | input | 1 | Converter disabled |
| ss_done | input | 1 | Soft-start finished |
| pg_pd_n | output | 1 | 0 = pull power-good low, 1 = release |
| ov_flag | output | 1 | Registered overvoltage state, not filtered |

## Verification
The bench builds the block with OV_DGL_NS=16 and FLAG_DGL_NS=32 at CLK_MHZ=250. That gives an overvoltage persistence of 4 edges and a release quiet time of 8 edges. These short windows let the bench pin each transition to its exact edge. They also let it show that a 2-edge overvoltage pulse is swallowed, and that a 1-cycle undervoltage dip restarts the release count. The reference code of 1000 places every threshold at a whole code: 870, 910, 1130 and 1165. Codes are therefore chosen just inside and just outside each hysteresis band.

// File: rtl/pg_mon_pkg.sv
package pg_mon_pkg;

   localparam int unsigned PM_UNIT = 1000;

   // code * 1000 strictly above refc * pm
   function automatic logic pm_above(input logic [31:0] code,
                                     input logic [31:0] refc,
                                     input logic [31:0] pm);
      return (code * PM_UNIT) > (refc * pm);
   endfunction

   // code * 1000 strictly below refc * pm
   function automatic logic pm_below(input logic [31:0] code,
                                     input logic [31:0] refc,
                                     input logic [31:0] pm);
      return (code * PM_UNIT) < (refc * pm);
   endfunction

endpackage

// File: rtl/pg_hyst_cmp.sv
module pg_hyst_cmp
   import pg_mon_pkg::*;
#(
   parameter int CODE_W = 12,
   parameter int SET_PM = 910,
   parameter int CLR_PM = 870
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] refc,
   output logic              state
);

   generate
      if (SET_PM <= CLR_PM) begin : g_bad_band
         $error("pg_hyst_cmp: SET_PM must exceed CLR_PM");
      end
   endgenerate

   logic go_high, go_low;

   always_comb begin
      go_high = pm_above(32'(code), 32'(refc), 32'(SET_PM));
      go_low  = pm_below(32'(code), 32'(refc), 32'(CLR_PM));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state <= 1'b0;
      else if (go_high) state <= 1'b1;
      else if (go_low)  state <= 1'b0;
   end

endmodule

// File: rtl/pg_rise_filter.sv
module pg_rise_filter #(
   parameter int HOLD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("pg_rise_filter: HOLD must be at least 1");
      end

      if (HOLD == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= 1'b0;
            else        dout <= din;
         end
      end else begin : g_count
         localparam int CW = $clog2(HOLD);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               dout <= 1'b0;
            end else if (!din) begin
               cnt  <= '0;
               dout <= 1'b0;
            end else if (cnt == CW'(HOLD - 1)) begin
               dout <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pg_window_mon.sv
module pg_window_mon #(
   parameter int CODE_W      = 12,
   parameter int CLK_MHZ     = 250,
   parameter int OV_DGL_NS   = 10000,
   parameter int FLAG_DGL_NS = 20000,
   parameter int UV_RISE_PM  = 910,
   parameter int UV_FALL_PM  = 870,
   parameter int OV_SET_PM   = 1165,
   parameter int OV_CLR_PM   = 1130
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] fb_code,
   input  logic [CODE_W-1:0] ss_code,
   input  logic [CODE_W-1:0] ref_code,
   input  logic              ilim_trip,
   input  logic              uvlo_act,
   input  logic              tsd_act,
   input  logic              en_wait,
   input  logic              off_req,
   input  logic              ss_done,
   output logic              pg_pd_n,
   output logic              ov_flag
);

   localparam int OV_HOLD = (CLK_MHZ * OV_DGL_NS) / 1000;
   localparam int PG_HOLD = (CLK_MHZ * FLAG_DGL_NS) / 1000;

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_width
         $error("pg_window_mon: CODE_W out of range 2..16");
      end
      if (OV_HOLD < 1 || PG_HOLD < 1) begin : g_bad_dgl
         $error("pg_window_mon: deglitch windows shorter than one clock");
      end
      if (OV_CLR_PM <= UV_RISE_PM) begin : g_bad_windows
         $error("pg_window_mon: overvoltage window overlaps undervoltage window");
      end
   endgenerate

   logic [CODE_W-1:0] mon_code;
   logic              uv_ok;
   logic              ov_raw;
   logic              ov_held;
   logic              force_low;
   logic              good_req;
   logic              pg_q;

   // during soft-start the ramp code is what the output is expected to follow
   assign mon_code = ss_done ? fb_code : ss_code;

   pg_hyst_cmp #(
      .CODE_W (CODE_W),
      .SET_PM (UV_RISE_PM),
      .CLR_PM (UV_FALL_PM)
   ) u_uv_win (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (mon_code),
      .refc  (ref_code),
      .state (uv_ok)
   );

   pg_hyst_cmp #(
      .CODE_W (CODE_W),
      .SET_PM (OV_SET_PM),
      .CLR_PM (OV_CLR_PM)
   ) u_ov_win (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (fb_code),
      .refc  (ref_code),
      .state (ov_raw)
   );

   pg_rise_filter #(.HOLD(OV_HOLD)) u_ov_dgl (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ov_raw),
      .dout  (ov_held)
   );

   assign force_low = ilim_trip | uvlo_act | tsd_act | en_wait | off_req;
   assign good_req  = ss_done & uv_ok & ~ov_held & ~force_low;

   pg_rise_filter #(.HOLD(PG_HOLD)) u_pg_dgl (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (good_req),
      .dout  (pg_q)
   );

   // force flags bypass every register on the way out
   assign pg_pd_n = pg_q & ~force_low;
   assign ov_flag = ov_raw;

endmodule

// File: rtl/pg_window_mon_chk.sv
module pg_window_mon_chk
   import pg_mon_pkg::*;
#(
   parameter int CODE_W    = 12,
   parameter int OV_SET_PM = 1165,
   parameter int OV_CLR_PM = 1130
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] fb_code,
   input logic [CODE_W-1:0] ref_code,
   input logic              ilim_trip,
   input logic              uvlo_act,
   input logic              tsd_act,
   input logic              en_wait,
   input logic              off_req,
   input logic              ss_done,
   input logic              pg_pd_n,
   input logic              ov_flag
);

   logic any_force, ov_hi, ov_lo;
   always_comb begin
      any_force = ilim_trip | uvlo_act | tsd_act | en_wait | off_req;
      ov_hi     = pm_above(32'(fb_code), 32'(ref_code), 32'(OV_SET_PM));
      ov_lo     = pm_below(32'(fb_code), 32'(ref_code), 32'(OV_CLR_PM));
   end

   p_forced_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      any_force |-> !pg_pd_n);

   p_ov_set_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ov_flag) |-> $past(ov_hi));

   p_ov_clr_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ov_flag) |-> $past(ov_lo));

   p_pg_after_ss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pg_pd_n |-> $past(ss_done));

   p_release_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_pd_n) |-> ($past(ss_done) && !$past(any_force)));

   always_comb begin
      if (!rst_n) begin
         a_reset_low_r1: assert (!pg_pd_n);
      end
   end

endmodule

bind pg_window_mon pg_window_mon_chk #(
   .CODE_W    (CODE_W),
   .OV_SET_PM (OV_SET_PM),
   .OV_CLR_PM (OV_CLR_PM)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fb_code   (fb_code),
   .ref_code  (ref_code),
   .ilim_trip (ilim_trip),
   .uvlo_act  (uvlo_act),
   .tsd_act   (tsd_act),
   .en_wait   (en_wait),
   .off_req   (off_req),
   .ss_done   (ss_done),
   .pg_pd_n   (pg_pd_n),
   .ov_flag   (ov_flag)
);

// File: tb/pg_window_mon_bench.sv
`timescale 1ns/1ps
module pg_window_mon_bench;

   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] fb_code = 12'd1000;
   logic [W-1:0] ss_code = 12'd1000;
   logic [W-1:0] ref_code = 12'd1000;
   logic         ilim_trip = 1'b0, uvlo_act = 1'b0, tsd_act = 1'b0;
   logic         en_wait = 1'b0, off_req = 1'b0, ss_done = 1'b0;
   logic         pg_pd_n, ov_flag;

   always #2 clk = ~clk;

   pg_window_mon #(
      .CODE_W      (W),
      .CLK_MHZ     (250),
      .OV_DGL_NS   (16),
      .FLAG_DGL_NS (32)
   ) u_pg_window_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .fb_code   (fb_code),
      .ss_code   (ss_code),
      .ref_code  (ref_code),
      .ilim_trip (ilim_trip),
      .uvlo_act  (uvlo_act),
      .tsd_act   (tsd_act),
      .en_wait   (en_wait),
      .off_req   (off_req),
      .ss_done   (ss_done),
      .pg_pd_n   (pg_pd_n),
      .ov_flag   (ov_flag)
   );

   typedef struct {
      int    at;
      int    pg;
      int    ov;
      string tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   total = 0;
   int   bad = 0;
   bit   finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_at(input int off, input int pg, input int ov, input string tag);
      exp_t e;
      e.at = cyc + off; e.pg = pg; e.ov = ov; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops expected items on their cycle
   always @(negedge clk) begin
      #1;
      while (q.size() > 0 && q[0].at <= cyc) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (e.at != cyc) begin
            bad++;
            $display("FAIL %s: missed sample cycle actual=%0d expected=%0d", e.tag, cyc, e.at);
         end else if (int'(pg_pd_n) != e.pg) begin
            bad++;
            $display("FAIL %s: pg_pd_n at cycle %0d actual=%0d expected=%0d", e.tag, cyc, pg_pd_n, e.pg);
         end else if (e.ov >= 0 && int'(ov_flag) != e.ov) begin
            bad++;
            $display("FAIL %s: ov_flag at cycle %0d actual=%0d expected=%0d", e.tag, cyc, ov_flag, e.ov);
         end
      end
   end

   task automatic set_force(input int which, input logic v);
      case (which)
         0: ilim_trip = v;
         1: uvlo_act  = v;
         2: tsd_act   = v;
         3: en_wait   = v;
         default: off_req = v;
      endcase
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: run state actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      step(3);
      // R1: outputs held low in reset
      expect_at(0, 0, 0, "R1");
      step(2);
      rst_n = 1'b1;
      step(20);
      // R6: soft-start not done keeps power-good low
      expect_at(0, 0, 0, "R6");
      step(1);

      // R7: release after 8 quiet edges
      ss_done = 1'b1;
      expect_at(7, 0, 0, "R7"); expect_at(8, 1, 0, "R7");
      step(10);

      // R2: inside the hysteresis band nothing changes
      fb_code = 12'd890;
      expect_at(3, 1, 0, "R2"); expect_at(12, 1, 0, "R2");
      step(13);
      fb_code = 12'd860;
      expect_at(1, 1, 0, "R2"); expect_at(2, 0, 0, "R2");
      step(4);
      fb_code = 12'd890;
      expect_at(12, 0, 0, "R2");
      step(13);
      fb_code = 12'd920;
      expect_at(8, 0, 0, "R2"); expect_at(9, 1, 0, "R2");
      step(10);

      // R7: one-cycle dip restarts the release count
      fb_code = 12'd860;
      expect_at(2, 0, 0, "R7"); expect_at(9, 0, 0, "R7"); expect_at(10, 1, 0, "R7");
      step(1);
      fb_code = 12'd1000;
      step(11);

      // R4: short overvoltage flagged but swallowed
      fb_code = 12'd1170;
      expect_at(1, 1, 1, "R3"); expect_at(3, 1, 0, "R4"); expect_at(10, 1, 0, "R4");
      step(2);
      fb_code = 12'd1000;
      step(10);

      // R3: band entered from below does not set the flag
      fb_code = 12'd1150;
      expect_at(3, 1, 0, "R3");
      step(4);

      // R4: sustained overvoltage
      fb_code = 12'd1170;
      expect_at(1, 1, 1, "R3"); expect_at(5, 1, 1, "R4"); expect_at(6, 0, 1, "R4");
      step(8);
      fb_code = 12'd1150;
      expect_at(3, 0, 1, "R3");
      step(4);
      fb_code = 12'd1120;
      expect_at(1, 0, 0, "R3"); expect_at(9, 0, 0, "R7"); expect_at(10, 1, 0, "R7");
      step(11);

      // R5: each force flag acts in the same cycle
      for (int f = 0; f < 5; f++) begin
         set_force(f, 1'b1);
         expect_at(0, 0, 0, "R5");
         step(3);
         set_force(f, 1'b0);
         expect_at(7, 0, 0, "R5"); expect_at(8, 1, 0, "R5");
         step(10);
      end

      // R6: soft-start re-entry watches the ramp code
      ss_code = 12'd800;
      ss_done = 1'b0;
      expect_at(1, 0, 0, "R6");
      step(5);
      ss_done = 1'b1;
      expect_at(8, 0, 0, "R6"); expect_at(9, 1, 0, "R6");
      step(12);

      finished = 1'b1;
      finish_run();
   end

endmodule